// File: doc/BRIEF.md
# Grid Scan and Duty Timer

This block paces the multiplexed scan of a dot-matrix fluorescent display. Running from the fast oscillator clock, it steps through sixteen digit slots of 1024 clocks each, in fixed order, and lights the grid of the current slot for a programmable number of clocks from the start of that slot. The segment datapath uses the scanned digit index to fetch the pattern for that digit. It uses the grid-active strobe to know when the lit window is open.

Brightness is set by a 10-bit on-time value. The value is capped so that every slot ends with a blank gap of at least 48 clocks. A 4-bit digit-count value limits how many grids light, starting from the first. A command decoder loads both values through one-cycle write strobes. The values written are held in a pending stage and reach the scan only at a frame boundary. The frame always contains all sixteen slots, so the frame rate does not depend on the digit count.

Top module: `grid_scan_timer`

## Requirements
- R1: While reset is held low at a clock edge, and from then on until a write changes them, all grid enables and grid_active are 0, digit_idx is 0, the on-time is 0 and the digit count is 0 (all sixteen digits).
- R2: A slot lasts 1024 clocks. digit_idx starts at 0 after reset, increments by one at each slot end and wraps from 15 to 0, so a frame is always 16384 clocks whatever the digit count.
- R3: In an enabled slot, the grid is lit from the first clock of the slot for exactly min(on-time, 976) consecutive clocks and is dark for the rest of the slot.
- R4: On-time values from 976 to 1023 all give 976 lit clocks, so the last 48 clocks of every slot are always dark.
- R5: An on-time of 0 keeps every grid dark.
- R6: With digit count K (cnt_val bits 3:0), the slots with index below K are enabled and the others stay dark. K = 0 enables all sixteen slots.
- R7: At most one bit of grid_en is set, and it is bit digit_idx. grid_active is 1 exactly when a grid bit is set.
- R8: A write (duty_wr with duty_val bits 9:0, or cnt_wr with cnt_val) is captured at the clock edge where its strobe is high. It is applied at the next edge that ends a frame (slot 15, clock 1023), and the frame in progress keeps its old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| duty_wr | input | 1 | One-cycle strobe that loads duty_val into the pending on-time |
| duty_val | input | 10 | On-time in clocks per slot, binary |
| cnt_wr | input | 1 | One-cycle strobe that loads cnt_val into the pending digit count |
| cnt_val | input | 4 | Number of lit digits, 0 meaning sixteen |
| grid_en | output | 16 | One-hot grid enables, bit n for digit slot n |
| digit_idx | output | 4 | Index of the slot being scanned |
| grid_active | output | 1 | High while the current slot's grid is lit |

## Verification
The assertions assume that the write strobes are synchronous to the oscillator clock and that each write is a single-cycle pulse with its value stable in that cycle. They place no limit on how often writes occur. The bench drives every strobe and value on the falling edge and holds it for exactly one rising edge. It writes at a fixed point early in a slot. One write deliberately lands in the middle of a frame, so that the deferred application can be observed against the old on-time.

// File: rtl/grid_scan_pkg.sv
// Shared defaults and helpers for the grid scan and duty timer.
// Assumes: slot length is a power of two and the cap is below it.
package grid_scan_pkg;
    localparam int unsigned DEF_GRIDS    = 16;
    localparam int unsigned DEF_SLOT_LEN = 1024;
    localparam int unsigned DEF_DUTY_W   = 10;
    localparam int unsigned DEF_DUTY_CAP = 976;

    // Clamp a requested on-time to the largest permitted lit window.
    function automatic int unsigned sat_on_time(int unsigned req, int unsigned cap);
        return (req > cap) ? cap : req;
    endfunction
endpackage

// File: rtl/gst_slot_timer.sv
// Slot timer: counts clocks inside a digit slot and steps the slot index
// through all grids in ascending order. Flags the last clock of a frame.
// Assumes: SLOT_LEN is a power of two, GRIDS >= 2.
module gst_slot_timer #(
    parameter int unsigned GRIDS    = grid_scan_pkg::DEF_GRIDS,
    parameter int unsigned SLOT_LEN = grid_scan_pkg::DEF_SLOT_LEN,
    localparam int unsigned CNT_W   = $clog2(SLOT_LEN),
    localparam int unsigned IDX_W   = $clog2(GRIDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] slot_cnt,
    output logic [IDX_W-1:0] slot_idx,
    output logic             frame_last
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(GRIDS - 1);

    logic slot_last;

    assign slot_last  = (slot_cnt == CNT_LAST);
    assign frame_last = slot_last && (slot_idx == IDX_LAST);

    // Advance the in-slot clock count and roll the slot index at slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_cnt <= '0;
            slot_idx <= '0;
        end else if (slot_last) begin
            slot_cnt <= '0;
            slot_idx <= (slot_idx == IDX_LAST) ? '0 : slot_idx + 1'b1;
        end else begin
            slot_cnt <= slot_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/gst_cfg_regs.sv
// Configuration stage: holds pending on-time and digit count written by the
// command decoder, and copies them to the active set only at frame end.
// Assumes: write strobes are single-cycle and synchronous to clk.
module gst_cfg_regs #(
    parameter int unsigned DUTY_W = grid_scan_pkg::DEF_DUTY_W,
    parameter int unsigned IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              duty_wr,
    input  logic [DUTY_W-1:0] duty_val,
    input  logic              cnt_wr,
    input  logic [IDX_W-1:0]  cnt_val,
    input  logic              frame_last,
    output logic [DUTY_W-1:0] act_duty,
    output logic [IDX_W-1:0]  act_cnt
);
    logic [DUTY_W-1:0] pend_duty;
    logic [IDX_W-1:0]  pend_cnt;

    // Capture decoder writes into the pending stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_duty <= '0;
            pend_cnt  <= '0;
        end else begin
            if (duty_wr) pend_duty <= duty_val;
            if (cnt_wr)  pend_cnt  <= cnt_val;
        end
    end

    // Promote pending values to the scan at the frame boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_duty <= '0;
            act_cnt  <= '0;
        end else if (frame_last) begin
            act_duty <= pend_duty;
            act_cnt  <= pend_cnt;
        end
    end
endmodule

// File: rtl/gst_grid_decode.sv
// Grid decode: opens the lit window at the start of each enabled slot for
// the capped on-time and drives the one-hot grid enable for that slot.
// Assumes: act_cnt of zero means every slot is enabled.
module gst_grid_decode #(
    parameter int unsigned GRIDS    = grid_scan_pkg::DEF_GRIDS,
    parameter int unsigned CNT_W    = 10,
    parameter int unsigned DUTY_W   = grid_scan_pkg::DEF_DUTY_W,
    parameter int unsigned DUTY_CAP = grid_scan_pkg::DEF_DUTY_CAP,
    localparam int unsigned IDX_W   = $clog2(GRIDS)
) (
    input  logic [CNT_W-1:0]  slot_cnt,
    input  logic [IDX_W-1:0]  slot_idx,
    input  logic [DUTY_W-1:0] act_duty,
    input  logic [IDX_W-1:0]  act_cnt,
    output logic [GRIDS-1:0]  grid_en,
    output logic              lit
);
    int unsigned on_clks;
    logic        slot_ok;

    // Decide whether the current clock lies inside an enabled lit window.
    always_comb begin
        on_clks = grid_scan_pkg::sat_on_time(int'(act_duty), DUTY_CAP);
        slot_ok = (act_cnt == '0) || (slot_idx < act_cnt);
        lit     = slot_ok && (int'(slot_cnt) < on_clks);
    end

    for (genvar g = 0; g < GRIDS; g++) begin : g_grid
        assign grid_en[g] = lit && (slot_idx == IDX_W'(g));
    end
endmodule

// File: rtl/grid_scan_timer.sv
// Top of the grid scan and duty timer. Scans all grids in a fixed frame,
// lights each enabled grid for the capped on-time, and applies new
// configuration at frame boundaries.
// Assumes: configuration strobes come from a decoder in the clk domain.
module grid_scan_timer #(
    parameter int unsigned GRIDS    = grid_scan_pkg::DEF_GRIDS,
    parameter int unsigned SLOT_LEN = grid_scan_pkg::DEF_SLOT_LEN,
    parameter int unsigned DUTY_W   = grid_scan_pkg::DEF_DUTY_W,
    parameter int unsigned DUTY_CAP = grid_scan_pkg::DEF_DUTY_CAP,
    localparam int unsigned IDX_W   = $clog2(GRIDS),
    localparam int unsigned CNT_W   = $clog2(SLOT_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              duty_wr,
    input  logic [DUTY_W-1:0] duty_val,
    input  logic              cnt_wr,
    input  logic [IDX_W-1:0]  cnt_val,
    output logic [GRIDS-1:0]  grid_en,
    output logic [IDX_W-1:0]  digit_idx,
    output logic              grid_active
);
    logic [CNT_W-1:0]  slot_cnt;
    logic [IDX_W-1:0]  slot_idx;
    logic              frame_last;
    logic [DUTY_W-1:0] act_duty;
    logic [IDX_W-1:0]  act_cnt;

    gst_slot_timer #(.GRIDS(GRIDS), .SLOT_LEN(SLOT_LEN)) u_timer (
        .clk(clk), .rst_n(rst_n), .slot_cnt(slot_cnt),
        .slot_idx(slot_idx), .frame_last(frame_last)
    );

    gst_cfg_regs #(.DUTY_W(DUTY_W), .IDX_W(IDX_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .duty_wr(duty_wr), .duty_val(duty_val),
        .cnt_wr(cnt_wr), .cnt_val(cnt_val), .frame_last(frame_last),
        .act_duty(act_duty), .act_cnt(act_cnt)
    );

    gst_grid_decode #(.GRIDS(GRIDS), .CNT_W(CNT_W), .DUTY_W(DUTY_W),
                      .DUTY_CAP(DUTY_CAP)) u_dec (
        .slot_cnt(slot_cnt), .slot_idx(slot_idx), .act_duty(act_duty),
        .act_cnt(act_cnt), .grid_en(grid_en), .lit(grid_active)
    );

    assign digit_idx = slot_idx;
endmodule

// File: rtl/grid_scan_timer_chk.sv
// Checker for grid_scan_timer: scan order, one-hot grids, blank gap,
// contiguous lit window and frame-aligned configuration.
// Assumes: bound to the top; sees the in-slot count and active on-time.
module grid_scan_timer_chk #(
    parameter int unsigned GRIDS    = 16,
    parameter int unsigned SLOT_LEN = 1024,
    parameter int unsigned DUTY_W   = 10,
    parameter int unsigned DUTY_CAP = 976,
    localparam int unsigned IDX_W   = $clog2(GRIDS),
    localparam int unsigned CNT_W   = $clog2(SLOT_LEN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [GRIDS-1:0]  grid_en,
    input logic [IDX_W-1:0]  digit_idx,
    input logic              grid_active,
    input logic [CNT_W-1:0]  slot_cnt,
    input logic [DUTY_W-1:0] act_duty
);
    assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grid_en));

    assert_idx_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grid_en != '0) |-> grid_en[digit_idx]);

    assert_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grid_active == (grid_en != '0));

    assert_blank_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(slot_cnt) >= DUTY_CAP) |-> (grid_en == '0));

    assert_zero_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_duty == '0) |-> !grid_active);

    assert_scan_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_cnt == '0 && $past(slot_cnt) == CNT_W'(SLOT_LEN - 1))
        |-> (digit_idx == IDX_W'($past(digit_idx) + 1'b1)));

    assert_contiguous_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grid_active && slot_cnt != '0) |-> $past(grid_active));

    assert_frame_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_cnt != '0 || digit_idx != '0) |-> $stable(act_duty));
endmodule

bind grid_scan_timer grid_scan_timer_chk #(
    .GRIDS(GRIDS), .SLOT_LEN(SLOT_LEN), .DUTY_W(DUTY_W), .DUTY_CAP(DUTY_CAP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .grid_en(grid_en), .digit_idx(digit_idx),
    .grid_active(grid_active), .slot_cnt(slot_cnt), .act_duty(act_duty)
);

// File: tb/tb_grid_scan_timer.sv
// Bench: behavioural frame model compared with the outputs on every clock,
// plus per-slot lit-time checks for a set of on-time and digit-count values.
module tb_grid_scan_timer;
    localparam int FRAME = 16384;
    localparam int SLOT  = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        duty_wr = 1'b0;
    logic [9:0]  duty_val = '0;
    logic        cnt_wr = 1'b0;
    logic [3:0]  cnt_val = '0;
    logic [15:0] grid_en;
    logic [3:0]  digit_idx;
    logic        grid_active;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state
    int m_pos = 0, m_pend_d = 0, m_act_d = 0, m_pend_k = 0, m_act_k = 0;
    int on_cnt = 0, last_slot_on = -1;

    grid_scan_timer dut (
        .clk(clk), .rst_n(rst_n), .duty_wr(duty_wr), .duty_val(duty_val),
        .cnt_wr(cnt_wr), .cnt_val(cnt_val), .grid_en(grid_en),
        .digit_idx(digit_idx), .grid_active(grid_active)
    );

    always #5 clk = ~clk;

    function automatic int exp_on(int duty, int k, int slot);
        if (!(k == 0 || slot < k)) return 0;
        return (duty > 976) ? 976 : duty;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // reference model update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_pend_d = 0; m_act_d = 0; m_pend_k = 0; m_act_k = 0;
        end else begin
            if (m_pos == FRAME - 1) begin
                m_act_d = m_pend_d;
                m_act_k = m_pend_k;
            end
            if (duty_wr) m_pend_d = int'(duty_val);
            if (cnt_wr)  m_pend_k = int'(cnt_val);
            m_pos = (m_pos + 1) % FRAME;
        end
    end

    // compare outputs on every falling edge, and lit time at slot end
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int slot, c, on;
            logic [15:0] eg;
            slot = m_pos / SLOT;
            c    = m_pos % SLOT;
            on   = exp_on(m_act_d, m_act_k, slot);
            eg   = (c < on) ? (16'd1 << slot) : 16'd0;
            check(grid_en == eg, "R2/R3/R6/R7 grid_en", int'(grid_en), int'(eg));
            check(digit_idx == 4'(slot), "R2 digit_idx", int'(digit_idx), slot);
            check(grid_active == (c < on), "R7 grid_active", int'(grid_active), int'(c < on));
            on_cnt += int'(grid_active);
            if (c == SLOT - 1) begin
                if (m_act_d == 0)
                    check(on_cnt == on, "R5 slot on-time", on_cnt, on);
                else if (!(m_act_k == 0 || slot < m_act_k))
                    check(on_cnt == on, "R6 slot on-time", on_cnt, on);
                else if (m_act_d >= 976)
                    check(on_cnt == on, "R4 slot on-time", on_cnt, on);
                else
                    check(on_cnt == on, "R3 slot on-time", on_cnt, on);
                last_slot_on = on_cnt;
                on_cnt = 0;
            end
        end
    end

    task automatic wait_pos(int p);
        do @(negedge clk); while (m_pos != p);
    endtask

    initial begin
        int cfg_d [6] = '{1, 975, 976, 1023, 600, 0};
        int cfg_k [6] = '{-1, 0, 0, 3, 1, 15};
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        check(grid_en == '0, "R1 grid_en in reset", int'(grid_en), 0);
        check(digit_idx == '0, "R1 digit_idx in reset", int'(digit_idx), 0);
        check(!grid_active, "R1 grid_active in reset", int'(grid_active), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            wait_pos(100);
            duty_wr  = 1'b1;
            duty_val = 10'(cfg_d[i]);
            if (cfg_k[i] >= 0) begin
                cnt_wr  = 1'b1;
                cnt_val = 4'(cfg_k[i]);
            end
            @(negedge clk);
            duty_wr = 1'b0;
            cnt_wr  = 1'b0;
            if (i == 2) begin
                // R8: slot 0 of this frame still uses the previous on-time
                wait_pos(1100);
                check(last_slot_on == 975, "R8 deferred apply", last_slot_on, 975);
            end
        end
        wait_pos(FRAME - 1);
        wait_pos(FRAME - 1);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule